// File: doc/BRIEF.md
# Settable 24-Hour Timekeeper

This block keeps time of day as hours, minutes and seconds. It runs from a fast system clock. An internal prescaler divides that clock into a one-cycle enable once per second, and every register in the block is clocked by the system clock. When the block is running, each enable advances the seconds. A seconds rollover advances the minutes, and a minutes rollover advances the hours. After 23:59:59 the time returns to 00:00:00.

The time can be set without a separate load path. Raising the set key and choosing a field on the two-bit mode input makes that field step up by one on every one-second enable. The carry chain is cut while this happens and the seconds are frozen. Lowering the key, or choosing a run code, resumes normal counting from the adjusted value at the next enable.

The six outputs are BCD digits, ready for a seven-segment decoder placed outside this block. The one-second enable is also brought out.

Top module: `clock24_core`

## Requirements
- R1: A synchronous reset sets all six digits and the prescaler to zero and holds `sec_tick` low. After the last reset edge, the first `sec_tick` is high after exactly TICK_DIV-1 further rising edges.
- R2: `sec_tick` is high for one cycle in every TICK_DIV cycles and low in all the other cycles.
- R3: In run, each tick raises the seconds by one. The seconds go from 59 to 00.
- R4: In run, a seconds rollover from 59 to 00 raises the minutes by one. A minutes rollover from 59 to 00 that occurs on the same tick raises the hours by one.
- R5: In run, a tick at 23:59:59 gives 00:00:00.
- R6: With `set_key`=1 and `mode`=2'b01, each tick raises the minutes by one. The minutes go from 59 to 00, the hours do not change, and the seconds hold their value.
- R7: With `set_key`=1 and `mode`=2'b10, each tick raises the hours by one. The hours go from 23 to 00, and the minutes and seconds hold their value.
- R8: When `set_key`=0, the block runs whatever the value of `mode`. Mode codes 2'b00 and 2'b11 also mean run when `set_key`=1.
- R9: When the block changes between run and an adjust mode, no tick is lost or counted twice. The field in use continues from its current value at the next tick.
- R10: The digits are BCD, with the tens digit on `*_tens` and the units digit on `*_ones`. The digit values are hours tens 0..2, seconds and minutes tens 0..5, and units 0..9.
- R11: The digits change only on the rising edge at which `sec_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 run, 01 adjust minutes, 10 adjust hours, 11 run |
| set_key | input | 1 | Debounced key level; 1 enables the adjust codes |
| sec_tick | output | 1 | One-cycle enable once per second |
| hr_tens | output | 4 | Hours tens digit (BCD) |
| hr_ones | output | 4 | Hours units digit (BCD) |
| min_tens | output | 4 | Minutes tens digit (BCD) |
| min_ones | output | 4 | Minutes units digit (BCD) |
| sec_tens | output | 4 | Seconds tens digit (BCD) |
| sec_ones | output | 4 | Seconds units digit (BCD) |

## Verification
The bench steps the time to 23:59:59 and applies one more tick.
- A design that cleared only some fields at that point would leave a stale 23 or 59 on the outputs.
- A design that let the minutes carry leak during adjust-minutes would change the hours when the minutes roll from 59 to 00.
- A design that kept the seconds running during adjust would move the seconds away from their frozen value.

The bench switches between run and the adjust codes right after a tick, with the key both low and high. A design that lost or doubled a tick at a mode change would end each step one count away from the expected value. Reset is applied in the middle of operation and the tick spacing is then measured. An off-by-one prescaler would show up as a gap of three or five cycles instead of four.

// File: rtl/clock24_pkg.sv
package clock24_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_ADJ_MIN = 2'b01,
        MODE_ADJ_HR  = 2'b10,
        MODE_RUN_ALT = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

endpackage

// File: rtl/clock24_prescaler.sv
module clock24_prescaler #(
    parameter int DIV = 27_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/clock24_bcd_field.sv
module clock24_bcd_field
    import clock24_pkg::*;
#(
    parameter int MODULUS = 60
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  inc,
    output bcd2_t value,
    output logic  wrap
);
    localparam int TOP_VAL = MODULUS - 1;
    localparam logic [3:0] TENS_TOP = 4'(TOP_VAL / 10);
    localparam logic [3:0] ONES_TOP = 4'(TOP_VAL % 10);

    bcd2_t val_d, val_q;
    logic  at_top;

    assign at_top = (val_q.tens == TENS_TOP) && (val_q.ones == ONES_TOP);

    always_comb begin
        val_d = val_q;
        if (inc) begin
            if (at_top) begin
                val_d = '0;
            end else if (val_q.ones == 4'd9) begin
                val_d.ones = 4'd0;
                val_d.tens = val_q.tens + 4'd1;
            end else begin
                val_d.ones = val_q.ones + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;
    assign wrap  = inc && at_top;

endmodule

// File: rtl/clock24_core.sv
module clock24_core
    import clock24_pkg::*;
#(
    parameter int TICK_DIV = 27_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       set_key,
    output logic       sec_tick,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones
);
    localparam int SEC_MOD = 60;
    localparam int MIN_MOD = 60;
    localparam int HR_MOD  = 24;

    clk_mode_e mode_sel;
    logic      adj_min, adj_hr, running;
    logic      sec_inc, min_inc, hr_inc;
    logic      sec_wrap, min_wrap, hr_wrap;
    bcd2_t     sec_v, min_v, hr_v;

    assign mode_sel = clk_mode_e'(mode);

    always_comb begin
        adj_min = set_key && (mode_sel == MODE_ADJ_MIN);
        adj_hr  = set_key && (mode_sel == MODE_ADJ_HR);
        running = !(adj_min || adj_hr);
        sec_inc = sec_tick && running;
        min_inc = running ? sec_wrap : (sec_tick && adj_min);
        hr_inc  = running ? min_wrap : (sec_tick && adj_hr);
    end

    clock24_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_tick)
    );

    clock24_bcd_field #(.MODULUS(SEC_MOD)) u_sec (
        .clk(clk), .rst(rst), .inc(sec_inc), .value(sec_v), .wrap(sec_wrap)
    );

    clock24_bcd_field #(.MODULUS(MIN_MOD)) u_min (
        .clk(clk), .rst(rst), .inc(min_inc), .value(min_v), .wrap(min_wrap)
    );

    clock24_bcd_field #(.MODULUS(HR_MOD)) u_hr (
        .clk(clk), .rst(rst), .inc(hr_inc), .value(hr_v), .wrap(hr_wrap)
    );

    logic unused_wrap;
    assign unused_wrap = hr_wrap;

    assign hr_tens  = hr_v.tens;
    assign hr_ones  = hr_v.ones;
    assign min_tens = min_v.tens;
    assign min_ones = min_v.ones;
    assign sec_tens = sec_v.tens;
    assign sec_ones = sec_v.ones;

endmodule

// File: rtl/clock24_chk.sv
module clock24_chk #(
    parameter int TICK_DIV = 27_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       set_key,
    input logic       sec_tick,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_ones
);
    logic [7:0]  hr, mn, sc;
    logic        adj_m, adj_h;
    logic [31:0] gap_q;

    assign hr    = {hr_tens, hr_ones};
    assign mn    = {min_tens, min_ones};
    assign sc    = {sec_tens, sec_ones};
    assign adj_m = set_key && (mode == 2'b01);
    assign adj_h = set_key && (mode == 2'b10);

    always_ff @(posedge clk) begin
        if (rst || sec_tick) begin
            gap_q <= '0;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (hr == 8'h00 && mn == 8'h00 && sc == 8'h00 && !sec_tick));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (gap_q == 32'(TICK_DIV - 1)));

    // R11
    digits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sec_tick) |-> ($stable(hr) && $stable(mn) && $stable(sc)));

    // R6
    adj_min_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_tick) && $past(adj_m)) |-> ($stable(hr) && $stable(sc)));

    // R7
    adj_hr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_tick) && $past(adj_h)) |-> ($stable(mn) && $stable(sc)));

    // R5
    midnight_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_tick) && !$past(adj_m) && !$past(adj_h) &&
         $past(hr) == 8'h23 && $past(mn) == 8'h59 && $past(sc) == 8'h59)
        |-> (hr == 8'h00 && mn == 8'h00 && sc == 8'h00));

    // R10
    bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (hr_tens <= 4'd2 && hr_ones <= 4'd9 && min_tens <= 4'd5 &&
         min_ones <= 4'd9 && sec_tens <= 4'd5 && sec_ones <= 4'd9));

endmodule

bind clock24_core clock24_chk #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .set_key(set_key), .sec_tick(sec_tick),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
    .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones)
);

// File: tb/tb_clock24_core.sv
module tb_clock24_core;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int NV = 15;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       set_key = 1'b0;
    logic       sec_tick;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    clock24_core #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .mode(mode), .set_key(set_key),
        .sec_tick(sec_tick), .hr_tens(hr_tens), .hr_ones(hr_ones),
        .min_tens(min_tens), .min_ones(min_ones),
        .sec_tens(sec_tens), .sec_ones(sec_ones)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // vector: {mode[27:26], key[25], ticks[24:17], hh[16:12], mm[11:6], ss[5:0]}
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'd5,  5'd0,  6'd0,  6'd5},
        {2'b01, 1'b1, 8'd3,  5'd0,  6'd3,  6'd5},
        {2'b10, 1'b1, 8'd2,  5'd2,  6'd3,  6'd5},
        {2'b01, 1'b0, 8'd2,  5'd2,  6'd3,  6'd7},
        {2'b11, 1'b1, 8'd1,  5'd2,  6'd3,  6'd8},
        {2'b10, 1'b1, 8'd22, 5'd0,  6'd3,  6'd8},
        {2'b10, 1'b1, 8'd23, 5'd23, 6'd3,  6'd8},
        {2'b01, 1'b1, 8'd57, 5'd23, 6'd0,  6'd8},
        {2'b01, 1'b1, 8'd59, 5'd23, 6'd59, 6'd8},
        {2'b00, 1'b0, 8'd51, 5'd23, 6'd59, 6'd59},
        {2'b00, 1'b0, 8'd1,  5'd0,  6'd0,  6'd0},
        {2'b00, 1'b0, 8'd60, 5'd0,  6'd1,  6'd0},
        {2'b01, 1'b1, 8'd58, 5'd0,  6'd59, 6'd0},
        {2'b00, 1'b0, 8'd60, 5'd1,  6'd0,  6'd0},
        {2'b00, 1'b1, 8'd15, 5'd1,  6'd0,  6'd15}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R3";
            1:       return "R6 seconds held";
            2:       return "R7";
            3, 4:    return "R8";
            5, 6:    return "R7 hour wrap";
            7:       return "R6 minute wrap keeps hours";
            8:       return "R6";
            9:       return "R9 resume";
            10:      return "R5";
            11, 13:  return "R4";
            12:      return "R9";
            default: return "R8 key with run code";
        endcase
    endfunction

    task automatic check_time(input int h, input int m, input int s, input string tag);
        logic [23:0] act, exp;
        act = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
        exp = {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (R10 digits): actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (sec_tick !== 1'b1) @(negedge clk);
        end
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int gap;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (sec_tick !== 1'b0) begin
            errors++;
            $display("FAIL R1 tick in reset: actual %b expected 0", sec_tick);
        end
        check_time(0, 0, 0, "R1 reset");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            mode    = VEC[v][27:26];
            set_key = VEC[v][25];
            wait_ticks(int'(VEC[v][24:17]));
            check_time(int'(VEC[v][16:12]), int'(VEC[v][11:6]), int'(VEC[v][5:0]),
                       vec_tag(v));
        end

        // R1 reset in the middle of operation
        mode = 2'b00;
        set_key = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sec_tick !== 1'b0) begin
            errors++;
            $display("FAIL R1 tick in reset: actual %b expected 0", sec_tick);
        end
        check_time(0, 0, 0, "R1 mid-run reset");
        rst = 1'b0;
        gap = 0;
        while (sec_tick !== 1'b1) begin
            @(negedge clk);
            gap++;
        end
        checks++;
        if (gap != DIV - 1) begin
            errors++;
            $display("FAIL R1 first tick: actual %0d expected %0d", gap, DIV - 1);
        end
        check_time(0, 0, 0, "R11 no change before tick edge");

        // R2 tick spacing and width
        for (int k = 0; k < 3; k++) begin
            gap = 0;
            @(negedge clk);
            gap++;
            checks++;
            if (sec_tick !== 1'b0) begin
                errors++;
                $display("FAIL R2 tick width: actual %b expected 0", sec_tick);
            end
            while (sec_tick !== 1'b1) begin
                @(negedge clk);
                gap++;
            end
            checks++;
            if (gap != DIV) begin
                errors++;
                $display("FAIL R2 tick period: actual %0d expected %0d", gap, DIV);
            end
        end
        @(negedge clk);
        check_time(0, 0, 4, "R3 after mid-run reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule